// File: doc/BRIEF.md
# Flash Command-Word Cycle Sequencer

This block turns a stream of packed 32-bit command words into cycles on an 8-bit parallel flash bus. It takes one word at a time from an address/command FIFO. Each word describes a single bus operation completely: a command latch, an address latch, a multi-byte data write, or a multi-byte data read. The sequencer drives the command-latch and address-latch enables, the active-low write and read strobes and the 8-bit I/O bus, and it watches the ready/busy line. Write data comes from a transmit byte FIFO. Read data goes into a receive byte FIFO.

Each finished word produces a one-cycle done pulse. A word can also ask for an interrupt pulse and can mark itself as the last cycle of an operation. Firmware builds a page access by queueing a command word, several address words, and a data word. On the command word it sets wait-for-ready, so that the done pulse comes only after the flash reports ready. Setup, strobe-low, hold and ready-timeout lengths are fixed by parameters and counted in clock cycles.

Top module: `flash_seq_top`

## Requirements
- R1: Bits 17:16 of a word choose the cycle type. 0 is address (ALE high), 1 is command (CLE high), 2 is data write and 3 is data read. CLE and ALE are never high together, and the write and read strobes are never low together.
- R2: A command or address word places its bits 7:0 on the I/O bus, with the output enable high for the whole byte. It holds its latch enable high for the whole byte. The bus is driven SETUP_CYC cycles before the write strobe falls. The write strobe stays low for PULSE_CYC cycles, and the bus is held HOLD_CYC cycles after it rises.
- R3: A data-write word carries the byte count minus one in bits 11:0, so 0 moves one byte. It gives one write strobe pulse per byte. Each byte is taken from the transmit FIFO in order and driven with the same setup, pulse and hold counts as in R2.
- R4: A data-read word uses the same count field. It gives one read strobe pulse of PULSE_CYC cycles per byte, with the output enable low. It samples the I/O bus in the last cycle the read strobe is low and pushes that byte into the receive FIFO.
- R5: When a write byte is due and the transmit FIFO is empty, the sequencer waits with both strobes high, both latch enables low and the bus not driven. It does not pop the FIFO until data is present.
- R6: When a read byte is due and the receive FIFO is full, the sequencer waits with the read strobe high. It does not push until space is present.
- R7: When bit 19 (wait-for-ready) is set, the done pulse comes only after the ready/busy input reads high (ready) following the last strobe.
- R8: When ready/busy stays low for TIMEOUT_CYC cycles while waiting, the sequencer gives a one-cycle error pulse instead of a done pulse. It then returns to idle and takes the next word.
- R9: Every word that finishes without error gives exactly one single-cycle done pulse. An interrupt pulse comes with it when bit 13 is set, and a last-cycle pulse comes with it when bit 18 is set.
- R10: Out of reset, CLE and ALE are low, both strobes are high and the bus is not driven. The command FIFO is popped only when it is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWord | input | 32 | Head word of the command FIFO (first-word fall-through) |
| cmdEmpty | input | 1 | Command FIFO empty |
| cmdRdEn | output | 1 | Pop the command FIFO |
| txData | input | 8 | Head byte of the transmit FIFO |
| txEmpty | input | 1 | Transmit FIFO empty |
| txRdEn | output | 1 | Pop the transmit FIFO |
| rxData | output | 8 | Byte pushed into the receive FIFO |
| rxFull | input | 1 | Receive FIFO full |
| rxWrEn | output | 1 | Push into the receive FIFO |
| flashCle | output | 1 | Command latch enable |
| flashAle | output | 1 | Address latch enable |
| flashWeN | output | 1 | Write strobe, active low |
| flashReN | output | 1 | Read strobe, active low |
| ioOut | output | 8 | I/O bus output value |
| ioOe | output | 1 | I/O bus output enable |
| ioIn | input | 8 | I/O bus input value |
| readyBusy | input | 1 | Flash ready (1) or busy (0) |
| cmdDone | output | 1 | Word finished |
| irq | output | 1 | Interrupt request pulse |
| lastDone | output | 1 | Word marked last cycle finished |
| cmdError | output | 1 | Ready timeout |

## Verification
The main test runs a table of words through the bench.

- **Command and address words.** Command words carrying 0x70 and 0x00, and address words carrying 0x12 and 0xFF, tell the two latch enables apart. They also show whether the byte field reaches the bus unchanged, including the all-zero and all-one values.
- **Write and read words.** Words with length fields 0, 2 and 3 separate the one-byte case from multi-byte counts and catch off-by-one errors in the count. The same words show whether transmit bytes and sampled read bytes keep their order.
- **Flag combinations.** Varying which of the interrupt, last-cycle and wait-for-ready bits are set shows whether each flag affects only its own output.
- **Directed cases.** Separate tests drain the transmit FIFO, fill the receive FIFO, and hold ready/busy low past the timeout. Each checks that the bus stays idle and that the sequencer then resumes.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  // Field positions inside a command word
  localparam int TYPE_LSB = 16;
  localparam int WFR_BIT  = 19;
  localparam int LAST_BIT = 18;
  localparam int IRQ_BIT  = 13;

  typedef enum logic [1:0] {
    CYC_ADDR  = 2'd0,
    CYC_CMD   = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_READ  = 2'd3
  } cycType_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchWord;
    logic loadByte;
    logic nextByte;
    logic tmrClr;
    logic capture;
    logic cle;
    logic ale;
    logic weLow;
    logic reLow;
    logic drive;
  } seqStrobes_t;

endpackage

// File: rtl/flash_seq_datapath.sv
module flash_seq_datapath
  import flash_seq_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int TMR_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobes_t      st,
  input  logic [31:0]      cmdWord,
  input  logic [7:0]       txData,
  input  logic [7:0]       ioIn,
  output cycType_t         cycType,
  output logic             wfr,
  output logic             lastFlag,
  output logic             irqFlag,
  output logic             byteLeftZero,
  output logic [TMR_W-1:0] tmr,
  output logic             flashCle,
  output logic             flashAle,
  output logic             flashWeN,
  output logic             flashReN,
  output logic [7:0]       ioOut,
  output logic             ioOe,
  output logic [7:0]       rxData,
  output logic             rxWrEn
);

  logic [LEN_W-1:0] byteCnt;
  logic [7:0]       cmdByte;
  logic [7:0]       outByte;

  // Word fields, captured when the word is popped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycType  <= CYC_ADDR;
      wfr      <= 1'b0;
      lastFlag <= 1'b0;
      irqFlag  <= 1'b0;
      cmdByte  <= '0;
    end else if (st.latchWord) begin
      cycType  <= cycType_t'(cmdWord[TYPE_LSB+1:TYPE_LSB]);
      wfr      <= cmdWord[WFR_BIT];
      lastFlag <= cmdWord[LAST_BIT];
      irqFlag  <= cmdWord[IRQ_BIT];
      cmdByte  <= cmdWord[7:0];
    end
  end

  // Remaining byte count (count minus one)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             byteCnt <= '0;
    else if (st.latchWord) byteCnt <= cmdWord[LEN_W-1:0];
    else if (st.nextByte)  byteCnt <= byteCnt - 1'b1;
  end
  assign byteLeftZero = (byteCnt == '0);

  // Byte to drive on the bus
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            outByte <= '0;
    else if (st.loadByte) outByte <= (cycType == CYC_WRITE) ? txData : cmdByte;
  end

  // Phase timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          tmr <= '0;
    else if (st.tmrClr) tmr <= '0;
    else                tmr <= tmr + 1'b1;
  end

  // Registered bus pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flashCle <= 1'b0;
      flashAle <= 1'b0;
      flashWeN <= 1'b1;
      flashReN <= 1'b1;
      ioOe     <= 1'b0;
      ioOut    <= '0;
    end else begin
      flashCle <= st.cle;
      flashAle <= st.ale;
      flashWeN <= ~st.weLow;
      flashReN <= ~st.reLow;
      ioOe     <= st.drive;
      ioOut    <= st.drive ? outByte : 8'h00;
    end
  end

  // Read capture and receive push
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rxWrEn <= 1'b0;
    end else begin
      rxWrEn <= st.capture;
      if (st.capture) rxData <= ioIn;
    end
  end

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 3,
  parameter int HOLD_CYC    = 2,
  parameter int TIMEOUT_CYC = 64,
  parameter int TMR_W       = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdEmpty,
  input  logic             txEmpty,
  input  logic             rxFull,
  input  logic             readyBusy,
  input  cycType_t         cycType,
  input  logic             wfr,
  input  logic             lastFlag,
  input  logic             irqFlag,
  input  logic             byteLeftZero,
  input  logic [TMR_W-1:0] tmr,
  output seqStrobes_t      st,
  output logic             cmdRdEn,
  output logic             txRdEn,
  output logic             cmdDone,
  output logic             irq,
  output logic             lastDone,
  output logic             cmdError
);

  localparam logic [TMR_W-1:0] SETUP_END = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] PULSE_END = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] HOLD_END  = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] WAIT_END  = TMR_W'(TIMEOUT_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_SETUP, S_PULSE, S_HOLD, S_WAIT, S_DONE, S_ERR
  } state_t;

  state_t state, stateNext;

  logic isRead, isWrite, isData;
  assign isRead  = (cycType == CYC_READ);
  assign isWrite = (cycType == CYC_WRITE);
  assign isData  = isRead | isWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    st        = '0;
    cmdRdEn   = 1'b0;
    txRdEn    = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (!cmdEmpty) begin
          cmdRdEn      = 1'b1;
          st.latchWord = 1'b1;
          stateNext    = S_START;
        end
      end
      S_START: begin
        if (isWrite) begin
          if (!txEmpty) begin
            txRdEn      = 1'b1;
            st.loadByte = 1'b1;
            st.tmrClr   = 1'b1;
            stateNext   = S_SETUP;
          end
        end else if (isRead) begin
          if (!rxFull) begin
            st.tmrClr = 1'b1;
            stateNext = S_SETUP;
          end
        end else begin
          st.loadByte = 1'b1;
          st.tmrClr   = 1'b1;
          stateNext   = S_SETUP;
        end
      end
      S_SETUP, S_PULSE, S_HOLD: begin
        st.cle   = (cycType == CYC_CMD);
        st.ale   = (cycType == CYC_ADDR);
        st.drive = !isRead;
        if (state == S_SETUP) begin
          if (tmr == SETUP_END) begin
            st.tmrClr = 1'b1;
            stateNext = S_PULSE;
          end
        end else if (state == S_PULSE) begin
          st.weLow = !isRead;
          st.reLow = isRead;
          if (tmr == PULSE_END) begin
            st.tmrClr = 1'b1;
            stateNext = S_HOLD;
          end
        end else begin
          st.capture = isRead && (tmr == '0);
          if (tmr == HOLD_END) begin
            st.tmrClr = 1'b1;
            if (isData && !byteLeftZero) begin
              st.nextByte = 1'b1;
              stateNext   = S_START;
            end else if (wfr) begin
              stateNext = S_WAIT;
            end else begin
              stateNext = S_DONE;
            end
          end
        end
      end
      S_WAIT: begin
        if (readyBusy)            stateNext = S_DONE;
        else if (tmr == WAIT_END) stateNext = S_ERR;
      end
      S_DONE:  stateNext = S_IDLE;
      S_ERR:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign cmdDone  = (state == S_DONE);
  assign irq      = cmdDone && irqFlag;
  assign lastDone = cmdDone && lastFlag;
  assign cmdError = (state == S_ERR);

endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
  import flash_seq_pkg::*;
#(
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 3,
  parameter int HOLD_CYC    = 2,
  parameter int TIMEOUT_CYC = 64,
  parameter int LEN_W       = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] cmdWord,
  input  logic        cmdEmpty,
  output logic        cmdRdEn,
  input  logic [7:0]  txData,
  input  logic        txEmpty,
  output logic        txRdEn,
  output logic [7:0]  rxData,
  input  logic        rxFull,
  output logic        rxWrEn,
  output logic        flashCle,
  output logic        flashAle,
  output logic        flashWeN,
  output logic        flashReN,
  output logic [7:0]  ioOut,
  output logic        ioOe,
  input  logic [7:0]  ioIn,
  input  logic        readyBusy,
  output logic        cmdDone,
  output logic        irq,
  output logic        lastDone,
  output logic        cmdError
);

  localparam int MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_B = (HOLD_CYC > TIMEOUT_CYC) ? HOLD_CYC : TIMEOUT_CYC;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W = $clog2(MAX_T + 1);

  seqStrobes_t      st;
  cycType_t         cycType;
  logic             wfr, lastFlag, irqFlag, byteLeftZero;
  logic [TMR_W-1:0] tmr;

  flash_seq_ctrl #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC), .TMR_W(TMR_W)
  ) ctrl (
    .clk(clk), .rstN(rstN), .cmdEmpty(cmdEmpty), .txEmpty(txEmpty),
    .rxFull(rxFull), .readyBusy(readyBusy), .cycType(cycType), .wfr(wfr),
    .lastFlag(lastFlag), .irqFlag(irqFlag), .byteLeftZero(byteLeftZero),
    .tmr(tmr), .st(st), .cmdRdEn(cmdRdEn), .txRdEn(txRdEn),
    .cmdDone(cmdDone), .irq(irq), .lastDone(lastDone), .cmdError(cmdError)
  );

  flash_seq_datapath #(.LEN_W(LEN_W), .TMR_W(TMR_W)) dp (
    .clk(clk), .rstN(rstN), .st(st), .cmdWord(cmdWord), .txData(txData),
    .ioIn(ioIn), .cycType(cycType), .wfr(wfr), .lastFlag(lastFlag),
    .irqFlag(irqFlag), .byteLeftZero(byteLeftZero), .tmr(tmr),
    .flashCle(flashCle), .flashAle(flashAle), .flashWeN(flashWeN),
    .flashReN(flashReN), .ioOut(ioOut), .ioOe(ioOe), .rxData(rxData),
    .rxWrEn(rxWrEn)
  );

endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker (
  input logic clk,
  input logic rstN,
  input logic cmdEmpty,
  input logic cmdRdEn,
  input logic txEmpty,
  input logic txRdEn,
  input logic rxFull,
  input logic rxWrEn,
  input logic flashCle,
  input logic flashAle,
  input logic flashWeN,
  input logic flashReN,
  input logic ioOe,
  input logic cmdDone,
  input logic irq,
  input logic lastDone,
  input logic cmdError
);

  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(!flashWeN && !flashReN));

  assert_latch_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(flashCle && flashAle));

  assert_we_drives_R2: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> ioOe);

  assert_we_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashWeN) |-> ioOe);

  assert_re_float_R4: assert property (@(posedge clk) disable iff (!rstN)
    !flashReN |-> !ioOe);

  assert_tx_pop_R5: assert property (@(posedge clk) disable iff (!rstN)
    txRdEn |-> !txEmpty);

  assert_rx_push_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxWrEn |-> !rxFull);

  assert_done_or_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdDone && cmdError));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> !cmdDone);

  assert_irq_with_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irq || lastDone) |-> cmdDone);

  assert_pop_nonempty_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdRdEn |-> !cmdEmpty);

endmodule

bind flash_seq_top flash_seq_checker chk (
  .clk(clk), .rstN(rstN), .cmdEmpty(cmdEmpty), .cmdRdEn(cmdRdEn),
  .txEmpty(txEmpty), .txRdEn(txRdEn), .rxFull(rxFull), .rxWrEn(rxWrEn),
  .flashCle(flashCle), .flashAle(flashAle), .flashWeN(flashWeN),
  .flashReN(flashReN), .ioOe(ioOe), .cmdDone(cmdDone), .irq(irq),
  .lastDone(lastDone), .cmdError(cmdError)
);

// File: tb/flash_seq_top_test.sv
module flash_seq_top_test;

  localparam int SETUP   = 2;
  localparam int PULSE   = 3;
  localparam int HOLD    = 2;
  localparam int TIMEOUT = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  // FIFO models
  logic [31:0] cmdMem [64];
  logic [7:0]  txMem  [64];
  logic [7:0]  rxMem  [64];
  int cmdWr = 0, cmdRd = 0, txWr = 0, txRd = 0, rxWr = 0;
  int rxCap = 64;

  logic [31:0] cmdWord;
  logic        cmdEmpty, cmdRdEn, txEmpty, txRdEn, rxFull, rxWrEn;
  logic [7:0]  txData, rxData, ioOut;
  logic [7:0]  ioIn = 8'h00;
  logic        readyBusy = 1'b1;
  logic        flashCle, flashAle, flashWeN, flashReN, ioOe;
  logic        cmdDone, irq, lastDone, cmdError;

  assign cmdWord  = cmdMem[cmdRd % 64];
  assign cmdEmpty = (cmdRd == cmdWr);
  assign txData   = txMem[txRd % 64];
  assign txEmpty  = (txRd == txWr);
  assign rxFull   = (rxWr >= rxCap);

  always @(posedge clk) begin
    if (cmdRdEn) cmdRd <= cmdRd + 1;
    if (txRdEn)  txRd  <= txRd + 1;
    if (rxWrEn) begin
      rxMem[rxWr % 64] <= rxData;
      rxWr <= rxWr + 1;
    end
  end

  flash_seq_top #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD),
                  .TIMEOUT_CYC(TIMEOUT)) uut (
    .clk(clk), .rstN(rstN), .cmdWord(cmdWord), .cmdEmpty(cmdEmpty),
    .cmdRdEn(cmdRdEn), .txData(txData), .txEmpty(txEmpty), .txRdEn(txRdEn),
    .rxData(rxData), .rxFull(rxFull), .rxWrEn(rxWrEn), .flashCle(flashCle),
    .flashAle(flashAle), .flashWeN(flashWeN), .flashReN(flashReN),
    .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn), .readyBusy(readyBusy),
    .cmdDone(cmdDone), .irq(irq), .lastDone(lastDone), .cmdError(cmdError)
  );

  // Bus monitor and flash model, sampled away from the active edge
  int cyc = 0, weCnt = 0, reCnt = 0, doneCnt = 0, irqCnt = 0, lastCnt = 0, errCnt = 0;
  int lowRun = 0, lowLen = 0, oeRun = 0, setupLen = 0, holdRun = 0, holdLen = 0;
  int riseCyc = 0, doneCyc = 0, rbHold = 0, rbLeft = 0, rdIdx = 0;
  bit inHold = 0, pWe = 1, pRe = 1, cleAt = 0, aleAt = 0;
  logic [7:0] lastByte = 8'h00;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (pWe && !flashWeN) begin
      setupLen = oeRun;
      lowRun = 0;
    end
    if (!flashWeN) lowRun = lowRun + 1;
    if (!pWe && flashWeN) begin
      weCnt = weCnt + 1;
      lowLen = lowRun;
      lastByte = ioOut;
      cleAt = flashCle;
      aleAt = flashAle;
      riseCyc = cyc;
      holdRun = 0;
      inHold = 1;
      if (flashCle && rbHold > 0) rbLeft = rbHold;
    end
    if (inHold) begin
      if (flashWeN && ioOe) holdRun = holdRun + 1;
      else begin
        holdLen = holdRun;
        inHold = 0;
      end
    end
    if (flashWeN && ioOe) oeRun = oeRun + 1;
    else oeRun = 0;
    if (pRe && !flashReN) begin
      reCnt = reCnt + 1;
      ioIn = 8'hA0 + 8'(rdIdx);
      rdIdx = rdIdx + 1;
    end
    pWe = flashWeN;
    pRe = flashReN;
    if (cmdDone) begin
      doneCnt = doneCnt + 1;
      doneCyc = cyc;
    end
    if (irq)      irqCnt  = irqCnt + 1;
    if (lastDone) lastCnt = lastCnt + 1;
    if (cmdError) errCnt  = errCnt + 1;
    if (rbLeft > 0) rbLeft = rbLeft - 1;
    readyBusy = (rbLeft == 0);
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic pushCmd(input logic [31:0] w);
    cmdMem[cmdWr % 64] = w;
    cmdWr = cmdWr + 1;
  endtask

  task automatic pushTx(input logic [7:0] b);
    txMem[txWr % 64] = b;
    txWr = txWr + 1;
  endtask

  task automatic waitEnd(input int doneBase, input int errBase);
    int n = 0;
    while (doneCnt == doneBase && errCnt == errBase && n < 3000) begin
      @(negedge clk);
      n++;
    end
    idle(3);
  endtask

  // Vector: word, WE pulses, RE pulses, CLE at rise, ALE at rise, irq, last, ready delay
  typedef struct packed {
    logic [31:0] word;
    logic [7:0]  nWe;
    logic [7:0]  nRe;
    logic        cle;
    logic        ale;
    logic        irqE;
    logic        lastE;
    logic [7:0]  rb;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h000D2070, 8'd1, 8'd0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd6},
    '{32'h00000012, 8'd1, 8'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0},
    '{32'h00090000, 8'd1, 8'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0},
    '{32'h00060003, 8'd4, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd0},
    '{32'h00032002, 8'd0, 8'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0},
    '{32'h00020000, 8'd1, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0},
    '{32'h00072000, 8'd0, 8'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd0},
    '{32'h000400FF, 8'd1, 8'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd0}
  };

  initial begin
    int dB, eB, wB, rB, iB, lB, xB, rdB;
    // R10: pins while in reset
    idle(4);
    check(flashCle == 0 && flashAle == 0, "R10 latch enables in reset", flashCle + flashAle, 0);
    check(flashWeN == 1 && flashReN == 1, "R10 strobes in reset", flashWeN + flashReN, 2);
    check(ioOe == 0 && cmdRdEn == 0, "R10 bus and pop in reset", ioOe + cmdRdEn, 0);
    rstN = 1'b1;
    idle(5);
    check(flashWeN == 1 && ioOe == 0 && doneCnt == 0, "R10 idle with empty queue", ioOe, 0);

    for (int v = 0; v < NV; v++) begin
      dB = doneCnt; eB = errCnt; wB = weCnt; rB = reCnt;
      iB = irqCnt; lB = lastCnt; xB = rxWr; rdB = rdIdx;
      rbHold = int'(VECS[v].rb);
      if (VECS[v].word[17:16] == 2'd2)
        for (int k = 0; k < int'(VECS[v].nWe); k++) pushTx(8'hC0 + 8'(k));
      pushCmd(VECS[v].word);
      waitEnd(dB, eB);
      check(doneCnt - dB == 1, "R9 one done per word", doneCnt - dB, 1);
      check(weCnt - wB == int'(VECS[v].nWe), "R3 write pulses", weCnt - wB, int'(VECS[v].nWe));
      check(reCnt - rB == int'(VECS[v].nRe), "R4 read pulses", reCnt - rB, int'(VECS[v].nRe));
      check(irqCnt - iB == int'(VECS[v].irqE), "R9 irq", irqCnt - iB, int'(VECS[v].irqE));
      check(lastCnt - lB == int'(VECS[v].lastE), "R9 last", lastCnt - lB, int'(VECS[v].lastE));
      if (VECS[v].nWe > 0) begin
        check(cleAt == VECS[v].cle && aleAt == VECS[v].ale, "R1 latch enable by type",
              {cleAt, aleAt}, {VECS[v].cle, VECS[v].ale});
        check(lowLen == PULSE, "R2 strobe low length", lowLen, PULSE);
        check(setupLen == SETUP, "R2 setup length", setupLen, SETUP);
        check(holdLen == HOLD, "R2 hold length", holdLen, HOLD);
        if (VECS[v].word[17:16] == 2'd2)
          check(lastByte == 8'hC0 + VECS[v].nWe - 8'd1, "R3 last written byte",
                lastByte, 8'hC0 + VECS[v].nWe - 8'd1);
        else
          check(lastByte == VECS[v].word[7:0], "R2 command/address byte",
                lastByte, VECS[v].word[7:0]);
      end
      if (VECS[v].nRe > 0) begin
        check(rxWr - xB == int'(VECS[v].nRe), "R4 bytes pushed", rxWr - xB, int'(VECS[v].nRe));
        for (int k = 0; k < int'(VECS[v].nRe); k++)
          check(rxMem[(xB + k) % 64] == 8'hA0 + 8'(rdB + k), "R4 read byte order",
                rxMem[(xB + k) % 64], 8'hA0 + 8'(rdB + k));
      end
      if (VECS[v].rb > 0)
        check(doneCyc - riseCyc >= rbHold, "R7 done after ready", doneCyc - riseCyc, rbHold);
      rbHold = 0;
    end

    // R5: transmit FIFO empty stalls the write
    dB = doneCnt; eB = errCnt; wB = weCnt;
    pushCmd(32'h00020001);
    idle(40);
    check(weCnt == wB, "R5 no strobe while tx empty", weCnt - wB, 0);
    check(flashWeN == 1 && ioOe == 0 && flashCle == 0 && flashAle == 0,
          "R5 bus idle while stalled", ioOe, 0);
    check(doneCnt == dB, "R5 no done while stalled", doneCnt - dB, 0);
    pushTx(8'h5A); pushTx(8'h6B);
    waitEnd(dB, eB);
    check(weCnt - wB == 2, "R5 resumes after data", weCnt - wB, 2);
    check(lastByte == 8'h6B, "R5 resumed byte", lastByte, 8'h6B);

    // R6: receive FIFO full stalls the read
    dB = doneCnt; eB = errCnt; rB = reCnt; xB = rxWr;
    rxCap = rxWr;
    pushCmd(32'h00030001);
    idle(40);
    check(reCnt == rB && flashReN == 1, "R6 no read strobe while full", reCnt - rB, 0);
    check(rxWr == xB, "R6 no push while full", rxWr - xB, 0);
    rxCap = 1000;
    waitEnd(dB, eB);
    check(reCnt - rB == 2, "R6 resumes after space", reCnt - rB, 2);

    // R8: ready timeout
    dB = doneCnt; eB = errCnt;
    rbHold = 200;
    pushCmd(32'h00090055);
    waitEnd(dB, eB);
    check(errCnt - eB == 1, "R8 error pulse", errCnt - eB, 1);
    check(doneCnt == dB, "R8 no done on timeout", doneCnt - dB, 0);
    check(cyc - riseCyc < 200, "R8 error before ready", cyc - riseCyc, 200);
    rbHold = 0;
    while (readyBusy == 0) @(negedge clk);
    idle(2);
    dB = doneCnt; eB = errCnt;
    pushCmd(32'h00090090);
    waitEnd(dB, eB);
    check(doneCnt - dB == 1 && errCnt == eB, "R8 recovers to idle", doneCnt - dB, 1);
    check(lastByte == 8'h90, "R8 next word executed", lastByte, 8'h90);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule